// File: doc/BRIEF.md
# Flash Busy-Phase Sequencer with Status Readout

This block carries out the busy phase of the three write-type operations of a small byte-wide flash array model: single-byte program, page erase and whole-array erase. A one-cycle start pulse brings in the operation type, the target address and the byte to write. The block then stays busy for a fixed number of clock cycles. Each operation type has its own cycle count, set by a parameter. When that count runs out, the block applies the operation to its internal byte array and drops the busy flag.

While the block is busy, a host read does not return array contents. It returns a status byte. Bit 7 is a polling bit that tells program and erase apart and marks when the operation is done. Bit 6 flips on every read, so a host can tell that work is still in progress by reading twice. Once the operation finishes, reads return array contents again without any further command. Command decoding and pin-level timing belong to a neighbouring block.

Top module: `flash_embedded_status`

## Requirements
- R1: After synchronous reset, `busy_o` is 0, `rd_data_o` is 0x00, and every byte of the array reads as 0xFF.
- R2: A start pulse with `op_i` = 0 (program), 1 (page erase) or 2 (whole-array erase), taken while `busy_o` is 0, raises `busy_o` on the next cycle. `busy_o` then stays high for exactly PROG_CYC, PAGE_CYC or CHIP_CYC cycles respectively. `op_i` = 3 is not an operation and leaves `busy_o` low.
- R3: While a program is busy, bit 7 of every read result is the inverse of bit 7 of the byte being programmed.
- R4: While either erase is busy, bit 7 of every read result is 0.
- R5: While an operation is busy, bit 6 of the read result is 0 on the first read after the start and inverts on each later read of the same operation.
- R6: A completed program leaves the target byte equal to its old value ANDed with the written byte, so a 1 is never created. A read issued in the first cycle after `busy_o` falls returns the updated array data.
- R7: Page erase sets every byte of the page that holds the given address to 0xFF. The page is the address bits above the low PAGE_W bits. Bytes of other pages keep their values.
- R8: Whole-array erase sets every byte to 0xFF.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored. The running operation keeps its length and result, and the ignored operation never modifies the array.
- R10: `rd_data_o` updates one cycle after a cycle with `rd_i` high. In cycles without `rd_i` it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start of an operation |
| op_i | input | 2 | Operation type: 0 program, 1 page erase, 2 whole-array erase, 3 none |
| addr_i | input | ADDR_W | Target byte address (any byte in the page for page erase) |
| data_i | input | 8 | Byte to program |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read result: array byte when idle, status byte when busy |
| busy_o | output | 1 | Operation in progress |

## Verification
`busy_o` is due one cycle after the start pulse, and `rd_data_o` is due one cycle after the read strobe. The array change becomes visible to a read issued in the first cycle where `busy_o` is low. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so every sample comes exactly one register stage after its stimulus. During a busy run it strobes a read in every cycle and counts the busy cycles. It checks the status bits of each read at the following falling edge. It checks the final count against the per-type length once `busy_o` is seen low.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_PAGE = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } fop_e;

    typedef struct packed {
        fop_e       op;
        logic [7:0] wdata;
    } fop_req_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Status byte shown while busy: polling bit, toggle bit, rest zero
    function automatic logic [7:0] status_byte(fop_e op, logic [7:0] wdata, logic tog);
        logic poll;
        poll = (op == OP_PROG) ? ~wdata[7] : 1'b0;
        return {poll, tog, 6'b000000};
    endfunction

    function automatic logic [7:0] prog_merge(logic [7:0] old_b, logic [7:0] new_b);
        return old_b & new_b;
    endfunction

endpackage

// File: rtl/fsg_timer.sv
module fsg_timer
    import flash_status_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PROG_CYC = 6,
    parameter int PAGE_CYC = 20,
    parameter int CHIP_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  fop_e op_i,
    output logic busy_o,
    output logic done_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    function automatic logic [CNT_W-1:0] reload(fop_e op);
        case (op)
            OP_PROG: return CNT_W'(PROG_CYC - 1);
            OP_PAGE: return CNT_W'(PAGE_CYC - 1);
            OP_CHIP: return CNT_W'(CHIP_CYC - 1);
            default: return '0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (load_i) begin
            busy_q <= 1'b1;
            cnt_q  <= reload(op_i);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

endmodule

// File: rtl/fsg_array.sv
module fsg_array
    import flash_status_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_i,
    input  fop_e              op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
        logic [7:0] cell_q;
        logic       hit_byte;
        logic       hit_page;

        assign hit_byte = (addr_i == MY_ADDR);
        assign hit_page = (addr_i[ADDR_W-1:PAGE_W] == MY_ADDR[ADDR_W-1:PAGE_W]);

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= ERASED_BYTE;
            end else if (commit_i) begin
                case (op_i)
                    OP_PROG: if (hit_byte) cell_q <= prog_merge(cell_q, wdata_i);
                    OP_PAGE: if (hit_page) cell_q <= ERASED_BYTE;
                    OP_CHIP: cell_q <= ERASED_BYTE;
                    default: ;
                endcase
            end
        end

        assign cells[i] = cell_q;
    end

    assign rd_data_o = cells[rd_addr_i];

endmodule

// File: rtl/fsg_status.sv
module fsg_status
    import flash_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart_i,
    input  logic       rd_i,
    input  logic       busy_i,
    input  fop_e       op_i,
    input  logic [7:0] wdata_i,
    input  logic [7:0] arr_i,
    output logic [7:0] rd_data_o
);

    logic       tog_q;
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b0;
        end else if (restart_i) begin
            tog_q <= 1'b0;
        end else if (rd_i && busy_i) begin
            tog_q <= ~tog_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 8'h00;
        end else if (rd_i) begin
            rd_q <= busy_i ? status_byte(op_i, wdata_i, tog_q) : arr_i;
        end
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/flash_embedded_status.sv
module flash_embedded_status
    import flash_status_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int PAGE_W   = 8,
    parameter int PROG_CYC = 6,
    parameter int PAGE_CYC = 20,
    parameter int CHIP_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o
);

    localparam int MAX_CYC = max3(PROG_CYC, PAGE_CYC, CHIP_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    fop_e              op_in;
    logic              accept;
    logic              busy;
    logic              done;
    fop_req_t          req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        arr_rd;

    assign op_in  = fop_e'(op_i);
    assign accept = start_i && !busy && (op_in != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '{op: OP_NONE, wdata: 8'h00};
            addr_q <= '0;
        end else if (accept) begin
            req_q  <= '{op: op_in, wdata: data_i};
            addr_q <= addr_i;
        end
    end

    fsg_timer #(
        .CNT_W   (CNT_W),
        .PROG_CYC(PROG_CYC),
        .PAGE_CYC(PAGE_CYC),
        .CHIP_CYC(CHIP_CYC)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load_i(accept),
        .op_i  (op_in),
        .busy_o(busy),
        .done_o(done)
    );

    fsg_array #(
        .ADDR_W(ADDR_W),
        .PAGE_W(PAGE_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .commit_i (done),
        .op_i     (req_q.op),
        .addr_i   (addr_q),
        .wdata_i  (req_q.wdata),
        .rd_addr_i(rd_addr_i),
        .rd_data_o(arr_rd)
    );

    fsg_status u_status (
        .clk      (clk),
        .rst      (rst),
        .restart_i(accept),
        .rd_i     (rd_i),
        .busy_i   (busy),
        .op_i     (req_q.op),
        .wdata_i  (req_q.wdata),
        .arr_i    (arr_rd),
        .rd_data_o(rd_data_o)
    );

    assign busy_o = busy;

endmodule

// File: rtl/flash_embedded_status_chk.sv
module flash_embedded_status_chk
    import flash_status_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int PROG_CYC = 6,
    parameter int PAGE_CYC = 20,
    parameter int CHIP_CYC = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [1:0]        op_i,
    input logic [7:0]        data_i,
    input logic              rd_i,
    input logic [7:0]        rd_data_o,
    input logic              busy_o
);

    logic       acc;
    logic [1:0] op_l;
    logic       d7_l;
    int         run_len;
    int         exp_len;
    logic       pend;
    logic       have_prev;
    logic       prev6;

    assign acc = start_i && !busy_o && (op_i != 2'd3);

    always_comb begin
        case (op_l)
            2'd0:    exp_len = PROG_CYC;
            2'd1:    exp_len = PAGE_CYC;
            default: exp_len = CHIP_CYC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_l      <= 2'd3;
            d7_l      <= 1'b0;
            run_len   <= 0;
            pend      <= 1'b0;
            have_prev <= 1'b0;
            prev6     <= 1'b0;
        end else begin
            pend <= rd_i && busy_o;
            if (acc) begin
                op_l      <= op_i;
                d7_l      <= data_i[7];
                run_len   <= 0;
                have_prev <= 1'b0;
            end else begin
                if (busy_o) run_len <= run_len + 1;
                if (pend) begin
                    prev6     <= rd_data_o[6];
                    have_prev <= 1'b1;
                end
            end
        end
    end

    // R2: busy length matches the operation type
    assert_busy_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> run_len == exp_len);

    // R3: program polling bit is the inverted data bit
    assert_prog_poll_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_i && busy_o && op_l == 2'd0) |=> rd_data_o[7] == ~d7_l);

    // R4: erase polling bit reads 0
    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_i && busy_o && op_l != 2'd0) |=> rd_data_o[7] == 1'b0);

    // R5: first status read shows toggle 0
    assert_tog_first_R5: assert property (@(posedge clk) disable iff (rst)
        (pend && !have_prev) |-> rd_data_o[6] == 1'b0);

    // R5: later status reads invert the toggle bit
    assert_tog_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (pend && have_prev) |-> rd_data_o[6] != prev6);

    // R10: read data holds without a strobe
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rd_data_o));

endmodule

bind flash_embedded_status flash_embedded_status_chk #(
    .ADDR_W  (ADDR_W),
    .PROG_CYC(PROG_CYC),
    .PAGE_CYC(PAGE_CYC),
    .CHIP_CYC(CHIP_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .op_i     (op_i),
    .data_i   (data_i),
    .rd_i     (rd_i),
    .rd_data_o(rd_data_o),
    .busy_o   (busy_o)
);

// File: tb/flash_embedded_status_bench.sv
module flash_embedded_status_bench;

    localparam int ADDR_W   = 10;
    localparam int PAGE_W   = 8;
    localparam int PROG_CYC = 6;
    localparam int PAGE_CYC = 20;
    localparam int CHIP_CYC = 40;
    localparam int DEPTH    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              start_i;
    logic [1:0]        op_i;
    logic [ADDR_W-1:0] addr_i;
    logic [7:0]        data_i;
    logic              rd_i;
    logic [ADDR_W-1:0] rd_addr_i;
    logic [7:0]        rd_data_o;
    logic              busy_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    flash_embedded_status #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
        .PROG_CYC(PROG_CYC), .PAGE_CYC(PAGE_CYC), .CHIP_CYC(CHIP_CYC)
    ) u_flash_embedded_status (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .data_i(data_i), .rd_i(rd_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o)
    );

    function automatic int dur_of(logic [1:0] op);
        case (op)
            2'd0:    return PROG_CYC;
            2'd1:    return PAGE_CYC;
            default: return CHIP_CYC;
        endcase
    endfunction

    function automatic logic poll_of(logic [1:0] op, logic [7:0] d);
        return (op == 2'd0) ? ~d[7] : 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_apply(input logic [1:0] op, input int a, input logic [7:0] d);
        case (op)
            2'd0: model[a] = model[a] & d;
            2'd1: for (int i = 0; i < DEPTH; i++)
                      if ((i >> PAGE_W) == (a >> PAGE_W)) model[i] = 8'hFF;
            2'd2: for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
            default: ;
        endcase
    endtask

    task automatic read_chk(input int a, input string req);
        @(negedge clk);
        rd_i = 1'b1;
        rd_addr_i = ADDR_W'(a);
        @(negedge clk);
        rd_i = 1'b0;
        chk(rd_data_o == model[a], req, rd_data_o, model[a]);
    endtask

    // Start one operation, read every busy cycle, check status and length
    task automatic run_op(input logic [1:0] op, input int a, input logic [7:0] d,
                          input bit interfere, input bit verbose);
        int  cnt;
        int  nrd;
        bit  pend;
        bit  bad;
        cnt = 0; nrd = 0; pend = 0; bad = 0;
        @(negedge clk);
        start_i = 1'b1; op_i = op; addr_i = ADDR_W'(a); data_i = d;
        @(negedge clk);
        start_i = 1'b0;
        while (cnt < 1000) begin
            if (pend) begin
                if (rd_data_o[7] != poll_of(op, d)) begin
                    bad = 1;
                    chk(0, (op == 2'd0) ? "R3 poll bit" : "R4 poll bit",
                        rd_data_o[7], poll_of(op, d));
                end
                if (rd_data_o[6] != 1'((nrd - 1) & 1)) begin
                    bad = 1;
                    chk(0, "R5 toggle bit", rd_data_o[6], (nrd - 1) & 1);
                end
            end
            if (busy_o) begin
                cnt++;
                rd_i = 1'b1;
                rd_addr_i = ADDR_W'(a);
                pend = 1;
                nrd++;
                if (interfere && cnt == 2) begin
                    start_i = 1'b1; op_i = 2'd2; addr_i = '0; data_i = 8'h00;
                end else begin
                    start_i = 1'b0;
                end
            end else begin
                rd_i = 1'b0;
                start_i = 1'b0;
                break;
            end
            @(negedge clk);
            pend = 1;
        end
        if (verbose && !bad) begin
            chk(1, (op == 2'd0) ? "R3" : "R4", 0, 0);
            chk(1, "R5", 0, 0);
        end
        chk(cnt == dur_of(op), interfere ? "R9 busy length" : "R2 busy length",
            cnt, dur_of(op));
        model_apply(op, a, d);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        rst = 1'b1; start_i = 0; op_i = 0; addr_i = '0; data_i = 0;
        rd_i = 0; rd_addr_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
        chk(rd_data_o == 8'h00, "R1 read data after reset", rd_data_o, 0);
        read_chk(37, "R1 erased array");
        read_chk(DEPTH - 1, "R1 erased array top");

        // R2/R3/R5/R6: program with bit 7 set and then with bit 7 clear
        run_op(2'd0, 5, 8'hA5, 0, 1);
        read_chk(5, "R6 program result");
        run_op(2'd0, 5, 8'hFF, 0, 0);
        read_chk(5, "R6 no 0 to 1");
        run_op(2'd0, 5, 8'h0F, 0, 1);
        read_chk(5, "R6 AND merge");

        // R6: first idle-cycle read sees the new data
        @(negedge clk);
        start_i = 1'b1; op_i = 2'd0; addr_i = ADDR_W'(9); data_i = 8'h3C;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        rd_i = 1'b1; rd_addr_i = ADDR_W'(9);
        @(negedge clk);
        rd_i = 1'b0;
        model[9] = model[9] & 8'h3C;
        chk(rd_data_o == model[9], "R6 first idle read", rd_data_o, model[9]);

        // R9: start during busy ignored
        run_op(2'd0, 12, 8'h81, 1, 0);
        read_chk(12, "R9 running op result");
        read_chk(5, "R9 no erase from ignored start");

        // R7: page erase
        run_op(2'd0, 'h105, 8'h12, 0, 0);
        run_op(2'd0, 'h0A5, 8'h34, 0, 0);
        run_op(2'd1, 'h1F0, 8'h00, 0, 1);
        read_chk('h105, "R7 selected page erased");
        read_chk('h1FF, "R7 selected page top");
        read_chk('h0A5, "R7 other page kept");
        read_chk(5, "R7 other page kept low");

        // R2: op 3 is not an operation
        @(negedge clk);
        start_i = 1'b1; op_i = 2'd3; addr_i = ADDR_W'(5); data_i = 8'h00;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b0, "R2 op 3 no busy", busy_o, 0);
        read_chk(5, "R2 op 3 no change");

        // Random programs and reads
        for (int k = 0; k < 30; k++) begin
            int a;
            logic [7:0] d;
            a = int'($urandom % DEPTH);
            d = 8'($urandom);
            run_op(2'd0, a, d, 0, 0);
            read_chk(a, "R6 random program");
            read_chk(int'($urandom % DEPTH), "R6 random read");
        end

        // R10: hold without strobe
        read_chk(5, "R10 read");
        @(negedge clk);
        rd_addr_i = ADDR_W'('h1FF);
        repeat (3) @(negedge clk);
        chk(rd_data_o == model[5], "R10 hold without strobe", rd_data_o, model[5]);

        // R8: whole-array erase
        run_op(2'd2, 7, 8'h00, 0, 1);
        read_chk(5, "R8 erased");
        read_chk('h0A5, "R8 erased page0");
        read_chk(DEPTH - 1, "R8 erased top");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule